// File: doc/BRIEF.md
# Tiling Fence Register Bank

This block holds a bank of fence entries, each marking one page-granular window of a 32-bit linear aperture as tiled, and answers lookups that ask which window, if any, covers a given aperture address. Each entry is 64 bits wide. Software reaches it over a plain 32-bit register port as a low word and a high word. The low word carries the start page, a pitch code, a tile-mode bit and an enable bit. The high word carries the last page of the window. Every word reads back exactly as written, so a read issued after each write confirms that the step has landed.

Lookups arrive on a valid/ready stream and leave on a second valid/ready stream one cycle later. A request is taken on a clock edge where `lk_valid` and `lk_ready` are both high. `lk_ready` is high whenever the result slot is empty or is being drained in that same cycle. A result is held unchanged for as long as `res_valid` is high and `res_ready` is low. A result carries a hit flag, the index of the winning entry, the stride in bytes and the tile mode.

Matching is gated by the enable bit of the low word. Software retargets an entry in three steps: it writes zero to the low word, then writes the new high word, then writes the low word with the enable bit set. An entry caught in the middle of this sequence therefore never matches. Address arithmetic for detiling and all memory traffic lie outside this block.

Top module: `tile_fence_bank`

## Requirements
- R1: After reset every word of every entry reads as zero, `res_valid` is low and `lk_ready` is high.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the word selected by `cfg_addr`. Bit 0 of `cfg_addr` picks the high word when 1 and the low word when 0, and the bits above it pick the entry. `cfg_rdata` returns the stored word at `cfg_addr` in the same cycle.
- R3: A lookup hits an entry when bit 0 (enable) of its low word is 1 and start ≤ addr[31:12] ≤ end. Start is low[31:12] and end is high[31:12]. Both bounds are inclusive.
- R4: An entry whose low-word enable bit is 0 never hits, whatever its other bits hold. This covers an all-zero entry and an entry whose high word has been written but whose low word has not yet been re-enabled.
- R5: When several entries hit, the result reports the lowest entry index.
- R6: On a hit, `res_idx` is the entry index, `res_mode` is low-word bit 1 (1 = Y tiling, 0 = X tiling), and `res_pitch` is (low[11:2] + 1) × 128 bytes.
- R7: On a miss, `res_hit`, `res_idx`, `res_pitch` and `res_mode` are all zero.
- R8: A request taken at one clock edge shows its result with `res_valid` high after that same edge. `lk_ready` equals `!res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, every result field holds steady.
- R9: When a register write and a lookup are taken at the same edge, the lookup is judged against the entry contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(NUM_FENCES)+1 | Word select: bit 0 picks high/low, upper bits pick the entry |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Readback of the word at cfg_addr |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high with lk_valid |
| lk_addr | input | 32 | Aperture address to look up |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Downstream accepts the result |
| res_hit | output | 1 | Address falls in an enabled entry |
| res_idx | output | $clog2(NUM_FENCES) | Index of the winning entry |
| res_pitch | output | 18 | Stride in bytes of the winning entry |
| res_mode | output | 1 | Tile mode: 1 = Y, 0 = X |

## Verification
A register write and a lookup can be taken at the same clock edge, and the lookup must see the contents from before the write. The bench provokes this by driving, in one cycle, the disabling write to an entry together with a lookup of an address inside that entry. It expects a hit on that entry, and then a follow-up lookup of the same address must move to the next covering entry. Random runs also overlap writes with lookups freely, and a bench model that applies each write only after scoring the coincident lookup judges the results.

// File: rtl/tile_fence_pkg.sv
package tile_fence_pkg;

  localparam int WORD_W          = 32;
  localparam int PAGE_LSB        = 12;
  localparam int PAGE_W          = WORD_W - PAGE_LSB;
  localparam int ENABLE_BIT      = 0;
  localparam int MODE_BIT        = 1;
  localparam int PITCH_LSB       = 2;
  localparam int PITCH_CODE_W    = PAGE_LSB - PITCH_LSB;
  localparam int STRIDE_UNIT_LOG2 = 7;
  localparam int PITCH_BYTES_W   = PITCH_CODE_W + 1 + STRIDE_UNIT_LOG2;

  typedef enum logic {
    TILE_X = 1'b0,
    TILE_Y = 1'b1
  } tile_mode_e;

  typedef struct packed {
    logic                     hit;
    logic [PITCH_BYTES_W-1:0] pitch;
    tile_mode_e               mode;
  } fence_result_t;

  function automatic logic [PITCH_BYTES_W-1:0] stride_bytes(
    input logic [PITCH_CODE_W-1:0] code
  );
    logic [PITCH_BYTES_W-1:0] units;
    units = PITCH_BYTES_W'(code) + PITCH_BYTES_W'(1);
    return units << STRIDE_UNIT_LOG2;
  endfunction

  function automatic logic [PAGE_W-1:0] page_of(input logic [WORD_W-1:0] word);
    return word[WORD_W-1:PAGE_LSB];
  endfunction

endpackage

// File: rtl/fence_regfile.sv
module fence_regfile
  import tile_fence_pkg::*;
#(
  parameter int NUM_FENCES = 8,
  localparam int IDX_W     = $clog2(NUM_FENCES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [IDX_W:0]                   addr,
  input  logic [WORD_W-1:0]                wdata,
  output logic [WORD_W-1:0]                rdata,
  output logic [NUM_FENCES-1:0][WORD_W-1:0] lo_words,
  output logic [NUM_FENCES-1:0][WORD_W-1:0] hi_words
);

  logic [IDX_W-1:0] sel_entry;
  logic             sel_high;

  assign sel_entry = addr[IDX_W:1];
  assign sel_high  = addr[0];

  for (genvar e = 0; e < NUM_FENCES; e++) begin : g_entry
    logic hit_this;
    assign hit_this = we && (sel_entry == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_words[e] <= '0;
        hi_words[e] <= '0;
      end else if (hit_this) begin
        if (sel_high) hi_words[e] <= wdata;
        else          lo_words[e] <= wdata;
      end
    end
  end

  assign rdata = sel_high ? hi_words[sel_entry] : lo_words[sel_entry];

  AST_READBACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((addr != $past(addr)) || (rdata == $past(wdata)))); // R2

endmodule

// File: rtl/fence_range_match.sv
module fence_range_match
  import tile_fence_pkg::*;
#(
  parameter int NUM_FENCES = 8
) (
  input  logic [NUM_FENCES-1:0][WORD_W-1:0] lo_words,
  input  logic [NUM_FENCES-1:0][WORD_W-1:0] hi_words,
  input  logic [PAGE_W-1:0]                 page,
  output logic [NUM_FENCES-1:0]             enabled,
  output logic [NUM_FENCES-1:0]             match
);

  for (genvar e = 0; e < NUM_FENCES; e++) begin : g_cmp
    logic [PAGE_W-1:0] first_pg;
    logic [PAGE_W-1:0] last_pg;
    logic              above_first;
    logic              below_last;

    assign first_pg    = page_of(lo_words[e]);
    assign last_pg     = page_of(hi_words[e]);
    assign enabled[e]  = lo_words[e][ENABLE_BIT];
    assign above_first = (page >= first_pg);
    assign below_last  = (page <= last_pg);
    assign match[e]    = enabled[e] && above_first && below_last;
  end

endmodule

// File: rtl/fence_pick_lowest.sv
module fence_pick_lowest #(
  parameter int NUM_FENCES = 8,
  localparam int IDX_W     = $clog2(NUM_FENCES)
) (
  input  logic [NUM_FENCES-1:0] match,
  output logic                  any,
  output logic [IDX_W-1:0]      idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_FENCES - 1; i >= 0; i--) begin
      if (match[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/tile_fence_bank.sv
module tile_fence_bank
  import tile_fence_pkg::*;
#(
  parameter int NUM_FENCES = 8,
  localparam int IDX_W     = $clog2(NUM_FENCES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [IDX_W:0]           cfg_addr,
  input  logic [WORD_W-1:0]        cfg_wdata,
  output logic [WORD_W-1:0]        cfg_rdata,
  input  logic                     lk_valid,
  output logic                     lk_ready,
  input  logic [WORD_W-1:0]        lk_addr,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic                     res_hit,
  output logic [IDX_W-1:0]         res_idx,
  output logic [PITCH_BYTES_W-1:0] res_pitch,
  output logic                     res_mode
);

  logic [NUM_FENCES-1:0][WORD_W-1:0] lo_words;
  logic [NUM_FENCES-1:0][WORD_W-1:0] hi_words;
  logic [NUM_FENCES-1:0]             enabled_vec;
  logic [NUM_FENCES-1:0]             match_vec;
  logic                              pick_hit;
  logic [IDX_W-1:0]                  pick_idx;
  logic [WORD_W-1:0]                 pick_lo;
  logic                              unused_offset;
  fence_result_t                     next_res;
  fence_result_t                     res_q;
  logic                              res_valid_q;
  logic [IDX_W-1:0]                  res_idx_q;
  logic                              take_req;

  assign unused_offset = ^lk_addr[PAGE_LSB-1:0];

  fence_regfile #(.NUM_FENCES(NUM_FENCES)) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .lo_words (lo_words),
    .hi_words (hi_words)
  );

  fence_range_match #(.NUM_FENCES(NUM_FENCES)) i_match (
    .lo_words (lo_words),
    .hi_words (hi_words),
    .page     (page_of(lk_addr)),
    .enabled  (enabled_vec),
    .match    (match_vec)
  );

  fence_pick_lowest #(.NUM_FENCES(NUM_FENCES)) i_pick (
    .match (match_vec),
    .any   (pick_hit),
    .idx   (pick_idx)
  );

  assign pick_lo = lo_words[pick_idx];

  always_comb begin
    next_res.hit   = pick_hit;
    next_res.pitch = '0;
    next_res.mode  = TILE_X;
    if (pick_hit) begin
      next_res.pitch = stride_bytes(pick_lo[PITCH_LSB +: PITCH_CODE_W]);
      next_res.mode  = tile_mode_e'(pick_lo[MODE_BIT]);
    end
  end

  assign lk_ready = !res_valid_q || res_ready;
  assign take_req = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_q       <= '0;
      res_idx_q   <= '0;
    end else if (lk_ready) begin
      res_valid_q <= lk_valid;
      if (lk_valid) begin
        res_q     <= next_res;
        res_idx_q <= pick_hit ? pick_idx : '0;
      end
    end
  end

  assign res_valid = res_valid_q;
  assign res_hit   = res_q.hit;
  assign res_pitch = res_q.pitch;
  assign res_mode  = res_q.mode;
  assign res_idx   = res_idx_q;

  AST_PICK_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    pick_hit |-> match_vec[pick_idx]); // R5

  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    pick_hit |-> ((match_vec & ((NUM_FENCES'(1) << pick_idx) - NUM_FENCES'(1))) == '0)); // R5

  AST_NO_HIT_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && (enabled_vec == '0)) |=> !res_hit); // R4

  AST_MISS_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_idx == '0 && res_pitch == '0 && !res_mode)); // R7

  AST_TAKE_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |=> res_valid); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit) && $stable(res_idx)
                                   && $stable(res_pitch) && $stable(res_mode))); // R8

endmodule

// File: tb/test_tile_fence_bank.sv
module test_tile_fence_bank;
  localparam int NUM   = 8;
  localparam int IDX_W = $clog2(NUM);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [IDX_W:0]   cfg_addr = '0;
  logic [31:0]      cfg_wdata = '0;
  logic [31:0]      cfg_rdata;
  logic             lk_valid = 1'b0;
  logic             lk_ready;
  logic [31:0]      lk_addr = '0;
  logic             res_valid;
  logic             res_ready = 1'b1;
  logic             res_hit;
  logic [IDX_W-1:0] res_idx;
  logic [17:0]      res_pitch;
  logic             res_mode;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [31:0] m_lo [NUM];
  logic [31:0] m_hi [NUM];

  always #4 clk = ~clk;

  tile_fence_bank #(.NUM_FENCES(NUM)) i_tile_fence_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_ready(res_ready), .res_hit(res_hit), .res_idx(res_idx),
    .res_pitch(res_pitch), .res_mode(res_mode)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_res(input logic [31:0] a);
    logic [31:0] r;
    r = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (m_lo[i][0] && a[31:12] >= m_lo[i][31:12] && a[31:12] <= m_hi[i][31:12]) begin
        r[0]     = 1'b1;
        r[3:1]   = 3'(i);
        r[4]     = m_lo[i][1];
        r[22:5]  = (18'(m_lo[i][11:2]) + 18'd1) * 18'd128;
      end
    end
    return r;
  endfunction

  task automatic check_res(input logic [31:0] e, input string tag);
    check(res_valid === 1'b1, {tag, " valid"}, res_valid, 1);
    check(res_hit === e[0], {tag, " hit"}, res_hit, e[0]);
    check(res_idx === e[3:1], {tag, " idx"}, res_idx, e[3:1]);
    check(res_mode === e[4], {tag, " mode"}, res_mode, e[4]);
    check(res_pitch === e[22:5], {tag, " pitch"}, res_pitch, e[22:5]);
  endtask

  task automatic wr(input int idx, input bit hi, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {IDX_W'(idx), hi}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (hi) m_hi[idx] = d; else m_lo[idx] = d;
  endtask

  task automatic rd(input int idx, input bit hi, input string tag);
    logic [31:0] e;
    e = hi ? m_hi[idx] : m_lo[idx];
    cfg_addr = {IDX_W'(idx), hi};
    #1;
    check(cfg_rdata === e, tag, cfg_rdata, e);
  endtask

  task automatic look(input logic [31:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    res_ready = 1'b1; lk_valid = 1'b1; lk_addr = a;
    e = expect_res(a);
    @(negedge clk);
    lk_valid = 1'b0;
    check_res(e, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] e1, e2;
    for (int i = 0; i < NUM; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < NUM; i++) begin
      rd(i, 0, "R1 reset low word");
      rd(i, 1, "R1 reset high word");
    end
    check(res_valid === 1'b0, "R1 res_valid after reset", res_valid, 0);
    check(lk_ready === 1'b1, "R1 lk_ready after reset", lk_ready, 1);
    // R4 all-zero bank never hits, R7 miss fields zero
    look(32'h0000_0000, "R4 zero bank page 0");
    look(32'h0001_5234, "R7 zero bank miss");

    // Entry 3: three-step update, partial state must not hit (R4)
    wr(3, 0, 32'h0);
    wr(3, 1, {20'h0001F, 12'h0});
    rd(3, 1, "R2 high word readback");
    look(32'h0001_5234, "R4 partial entry");
    wr(3, 0, {20'h00010, 10'd3, 1'b1, 1'b1});
    rd(3, 0, "R2 low word readback");
    look(32'h0001_5234, "R6 entry3 Y pitch512");
    // R3 boundaries
    look(32'h0000_FFFF, "R3 below start");
    look(32'h0001_0000, "R3 at start");
    look(32'h0001_FFFF, "R3 at end");
    look(32'h0002_0000, "R3 past end");

    // Entry 1 overlapping, X mode: R5
    wr(1, 1, {20'h00040, 12'hABC});
    wr(1, 0, {20'h00018, 10'd0, 1'b0, 1'b1});
    look(32'h0001_C000, "R5 overlap lowest index");
    look(32'h0001_2000, "R5 only entry3");
    look(32'h0004_1000, "R7 miss after entries");
    // max pitch code, top page
    wr(7, 1, 32'hFFFF_F000);
    wr(7, 0, {20'hFFFFF, 10'h3FF, 1'b0, 1'b1});
    look(32'hFFFF_F800, "R6 max pitch top page");

    // R8 stall: result held while res_ready low
    @(negedge clk);
    res_ready = 1'b0; lk_valid = 1'b1; lk_addr = 32'h0001_C000;
    e1 = expect_res(32'h0001_C000);
    @(negedge clk);
    lk_addr = 32'h0001_2000;
    e2 = expect_res(32'h0001_2000);
    for (int k = 0; k < 3; k++) begin
      check(lk_ready === 1'b0, "R8 lk_ready low while stalled", lk_ready, 0);
      check_res(e1, "R8 held result");
      @(negedge clk);
    end
    res_ready = 1'b1;
    #1;
    check(lk_ready === 1'b1, "R8 lk_ready follows res_ready", lk_ready, 1);
    @(negedge clk);
    lk_valid = 1'b0;
    check_res(e2, "R8 second after release");
    @(negedge clk);
    check(res_valid === 1'b0, "R8 slot drains", res_valid, 0);

    // R9 write and lookup at the same edge
    @(negedge clk);
    res_ready = 1'b1;
    cfg_we = 1'b1; cfg_addr = {IDX_W'(1), 1'b0}; cfg_wdata = 32'h0;
    lk_valid = 1'b1; lk_addr = 32'h0001_C000;
    e1 = expect_res(32'h0001_C000);
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
    m_lo[1] = 32'h0;
    check_res(e1, "R9 same-edge sees old entry");
    check(res_idx === 3'd1, "R9 idx old entry", res_idx, 1);
    look(32'h0001_C000, "R9 next lookup sees new entry");

    // random mix, with concurrent writes
    for (int it = 0; it < 600; it++) begin
      int          op;
      int          idx;
      logic [19:0] sp;
      logic [31:0] a;
      logic [31:0] d;
      op  = $urandom_range(0, 9);
      idx = $urandom_range(0, NUM - 1);
      sp  = 20'($urandom_range(0, 200));
      a   = {20'($urandom_range(0, 255)), 12'($urandom)};
      if (op < 3) begin
        d = {sp, 10'($urandom), 1'($urandom), ($urandom_range(0, 3) != 0)};
        wr(idx, 0, d);
      end else if (op < 5) begin
        d = {sp + 20'($urandom_range(0, 40)), 12'($urandom)};
        wr(idx, 1, d);
      end else if (op < 6) begin
        @(negedge clk);
        rd(idx, op[0], "R2 random readback");
      end else if (op < 8) begin
        look(a, "R3 random lookup");
      end else begin
        @(negedge clk);
        d = {sp, 10'($urandom), 1'($urandom), 1'b1};
        res_ready = 1'b1;
        cfg_we = 1'b1; cfg_addr = {IDX_W'(idx), 1'b0}; cfg_wdata = d;
        lk_valid = 1'b1; lk_addr = a;
        e1 = expect_res(a);
        @(negedge clk);
        cfg_we = 1'b0; lk_valid = 1'b0;
        m_lo[idx] = d;
        check_res(e1, "R9 random same-edge");
      end
    end

    // R1 reset clears a populated bank
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NUM; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    for (int i = 0; i < NUM; i++) begin
      rd(i, 0, "R1 re-reset low word");
      rd(i, 1, "R1 re-reset high word");
    end
    check(res_valid === 1'b0, "R1 res_valid after re-reset", res_valid, 0);
    look(32'hFFFF_F000, "R1 no hit after re-reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule